// File: doc/BRIEF.md
# Asynchronous Character Frame Encoder and Checker

This block handles one asynchronous serial character as a parallel word. On the transmit side it takes a data byte and a set of line settings: word length from 5 to 8 bits, parity on or off, even or odd sense, forced (stick) parity, and one or two stop bits. It returns every bit of the frame that follows the start bit, packed least significant first, together with the number of bits it holds. On the receive side, a frame packed the same way is checked under a second, independent set of line settings. The checker returns the data, a parity error and a framing error.

The block also gives the time one whole character occupies on the line, measured in divisor-clock ticks. A baud divisor is supplied, and the result comes out in half-bit units so that a stop time of one and a half bits is still an exact integer. The encoder and checker are purely combinational. The duration is registered.

Both line-setting inputs share one 6-bit encoding:
- bits [1:0]: word length code; the character has 5 plus this value data bits.
- bit 2: two stop bits.
- bit 3: parity enable.
- bit 4: even parity, where 0 means odd.
- bit 5: stick parity.

Top module: `async_frame_codec`

## Requirements
- R1: `tx_frame` bits [n-1:0] hold `tx_data` masked to n = 5 + `tx_ctl[1:0]` bits, so data bits at or above n never appear in the frame.
- R2: With parity enabled (bit 3) and even parity selected (bit 4 = 1), `tx_frame[n]` is the XOR of the masked data bits.
- R3: With parity enabled and odd parity selected (bit 4 = 0), `tx_frame[n]` is the complement of the XOR of the masked data bits.
- R4: With parity enabled and stick parity set (bit 5), `tx_frame[n]` is 1 whatever the data and the even/odd bit.
- R5: After the data bits, or after the parity bit when parity is enabled, comes one stop bit of 1. A second 1 follows it when bit 2 is set. `tx_len` gives the total bit count, and every `tx_frame` bit at or above `tx_len` is 0.
- R6: `rx_data` is `rx_frame` masked to the word length selected by `rx_ctl[1:0]`, with the higher bits at 0.
- R7: With parity and stick parity enabled in `rx_ctl`, `rx_parity_err` is 1 exactly when the received parity bit `rx_frame[n]` is 0.
- R8: With parity enabled and stick parity off, `rx_parity_err` is 1 when the XOR of the data bits and the received parity bit is 1 under even parity, or 0 under odd parity. With parity disabled, `rx_parity_err` is 0.
- R9: `rx_frame_err` is 1 when the first stop bit is 0. When `rx_ctl` bit 2 is set, it is also 1 when the second stop bit is 0.
- R10: `dur_half` equals `divisor` times the half-bit count 2*(1 + n + parity) + S. Here S is 4 for two stop bits with n of 6 to 8, 3 for two stop bits with n = 5, and 2 for one stop bit.
- R11: `dur_half` is 0 after reset. It takes the value for `divisor` and `tx_ctl` one clock edge after they are applied, and holds it until the next edge.
- R12: A frame produced by the encoder and fed to the checker under the same line settings gives the original masked data and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ctl | input | 6 | Transmit line settings |
| tx_data | input | 8 | Character to encode |
| tx_frame | output | 11 | Packed frame after the start bit |
| tx_len | output | 4 | Number of valid bits in tx_frame |
| rx_ctl | input | 6 | Receive line settings |
| rx_frame | input | 11 | Packed received frame after the start bit |
| rx_data | output | 8 | Decoded character |
| rx_parity_err | output | 1 | Parity mismatch |
| rx_frame_err | output | 1 | A stop bit read as 0 |
| divisor | input | DIV_W | Divisor-clock ticks per bit |
| dur_half | output | DIV_W+5 | Character duration in half-bit ticks, registered |

## Verification
The only internal state is the registered duration. A fault there appears on `dur_half` at the first sample after the clock edge that follows a change of divisor or line settings, or during the step just before that edge if the register is bypassed. Errors in the combinational parts show up at once in the same cycle as the inputs. A wrong bit position shifts the parity or stop bit by one and is caught by any vector whose word length makes that bit differ. A wrong parity sense or a missed second stop bit flips an error flag on the matching crafted frame.

// File: rtl/frame_pkg.sv
package frame_pkg;

    localparam int MAX_DATA = 8;
    localparam int FRAME_W  = MAX_DATA + 3;
    localparam int LEN_W    = 4;
    localparam int CTL_W    = 6;
    localparam int HALF_W   = 5;

    typedef struct packed {
        logic       par_stick;
        logic       par_even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } line_ctl_t;

    typedef enum logic [2:0] {
        STOP_ONE      = 3'd2,
        STOP_ONE_HALF = 3'd3,
        STOP_TWO      = 3'd4
    } stop_half_e;

    function automatic logic [LEN_W-1:0] data_bits(input logic [1:0] wlen);
        return LEN_W'(5) + LEN_W'(wlen);
    endfunction

    function automatic logic [MAX_DATA-1:0] data_mask(input logic [1:0] wlen);
        logic [MAX_DATA-1:0] m;
        for (int i = 0; i < MAX_DATA; i++)
            m[i] = (i < int'(data_bits(wlen)));
        return m;
    endfunction

endpackage

// File: rtl/frame_encoder.sv
module frame_encoder
    import frame_pkg::*;
(
    input  line_ctl_t            ctl,
    input  logic [MAX_DATA-1:0]  data,
    output logic [FRAME_W-1:0]   frame,
    output logic [LEN_W-1:0]     len
);

    logic [MAX_DATA-1:0] masked;
    logic                pbit;
    logic [LEN_W-1:0]    pos;

    always_comb begin
        masked = data & data_mask(ctl.wlen);
        if (ctl.par_stick)
            pbit = 1'b1;
        else if (ctl.par_even)
            pbit = ^masked;
        else
            pbit = ~(^masked);

        frame = '0;
        frame[MAX_DATA-1:0] = masked;
        pos = data_bits(ctl.wlen);
        if (ctl.par_en) begin
            frame[pos] = pbit;
            pos = pos + LEN_W'(1);
        end
        frame[pos] = 1'b1;
        pos = pos + LEN_W'(1);
        if (ctl.two_stop) begin
            frame[pos] = 1'b1;
            pos = pos + LEN_W'(1);
        end
        len = pos;
    end

endmodule

// File: rtl/frame_checker.sv
module frame_checker
    import frame_pkg::*;
(
    input  line_ctl_t            ctl,
    input  logic [FRAME_W-1:0]   frame,
    output logic [MAX_DATA-1:0]  data,
    output logic                 parity_err,
    output logic                 framing_err
);

    logic [LEN_W-1:0] pos;
    logic             pbit;
    logic             sum;

    always_comb begin
        data = frame[MAX_DATA-1:0] & data_mask(ctl.wlen);
        pos  = data_bits(ctl.wlen);
        pbit = frame[pos];
        sum  = (^data) ^ pbit;
        parity_err = 1'b0;
        if (ctl.par_en) begin
            if (ctl.par_stick)
                parity_err = ~pbit;
            else if (ctl.par_even)
                parity_err = sum;
            else
                parity_err = ~sum;
            pos = pos + LEN_W'(1);
        end
        framing_err = ~frame[pos];
        if (ctl.two_stop)
            framing_err = framing_err | ~frame[pos + LEN_W'(1)];
    end

endmodule

// File: rtl/frame_timer.sv
module frame_timer
    import frame_pkg::*;
#(
    parameter int DIV_W = 16,
    localparam int DUR_W = DIV_W + HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ctl_t         ctl,
    input  logic [DIV_W-1:0]  divisor,
    output logic [DUR_W-1:0]  dur
);

    stop_half_e        stop_len;
    logic [HALF_W-1:0] half_cnt;

    always_comb begin
        if (!ctl.two_stop)
            stop_len = STOP_ONE;
        else if (ctl.wlen == 2'd0)
            stop_len = STOP_ONE_HALF;
        else
            stop_len = STOP_TWO;
        half_cnt = HALF_W'(2) * (HALF_W'(1) + HALF_W'(data_bits(ctl.wlen))
                                 + HALF_W'(ctl.par_en))
                   + HALF_W'(stop_len);
    end

    always_ff @(posedge clk) begin
        if (rst)
            dur <= '0;
        else
            dur <= DUR_W'(divisor) * DUR_W'(half_cnt);
    end

endmodule

// File: rtl/async_frame_codec.sv
module async_frame_codec
    import frame_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CTL_W-1:0]            tx_ctl,
    input  logic [MAX_DATA-1:0]         tx_data,
    output logic [FRAME_W-1:0]          tx_frame,
    output logic [LEN_W-1:0]            tx_len,
    input  logic [CTL_W-1:0]            rx_ctl,
    input  logic [FRAME_W-1:0]          rx_frame,
    output logic [MAX_DATA-1:0]         rx_data,
    output logic                        rx_parity_err,
    output logic                        rx_frame_err,
    input  logic [DIV_W-1:0]            divisor,
    output logic [DIV_W+HALF_W-1:0]     dur_half
);

    line_ctl_t tx_cfg;
    line_ctl_t rx_cfg;

    assign tx_cfg = line_ctl_t'(tx_ctl);
    assign rx_cfg = line_ctl_t'(rx_ctl);

    frame_encoder u_enc (
        .ctl   (tx_cfg),
        .data  (tx_data),
        .frame (tx_frame),
        .len   (tx_len)
    );

    frame_checker u_chk_rx (
        .ctl         (rx_cfg),
        .frame       (rx_frame),
        .data        (rx_data),
        .parity_err  (rx_parity_err),
        .framing_err (rx_frame_err)
    );

    frame_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ctl     (tx_cfg),
        .divisor (divisor),
        .dur     (dur_half)
    );

endmodule

// File: rtl/frame_codec_checker.sv
module frame_codec_checker
    import frame_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic                        clk,
    input logic                        rst,
    input logic [CTL_W-1:0]            tx_ctl,
    input logic [MAX_DATA-1:0]         tx_data,
    input logic [FRAME_W-1:0]          tx_frame,
    input logic [LEN_W-1:0]            tx_len,
    input logic [CTL_W-1:0]            rx_ctl,
    input logic [FRAME_W-1:0]          rx_frame,
    input logic [MAX_DATA-1:0]         rx_data,
    input logic                        rx_parity_err,
    input logic                        rx_frame_err,
    input logic [DIV_W-1:0]            divisor,
    input logic [DIV_W+HALF_W-1:0]     dur_half
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R5
    last_stop_one_chk: assert property (@(posedge clk) disable iff (rst)
        tx_frame[tx_len - LEN_W'(1)] == 1'b1);

    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_frame >> tx_len) == '0);

    // R4
    stick_one_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_ctl[5] && tx_ctl[3]) |-> tx_frame[data_bits(tx_ctl[1:0])] == 1'b1);

    // R12
    loopback_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ctl == tx_ctl && rx_frame == tx_frame) |->
        (!rx_parity_err && !rx_frame_err &&
         rx_data == (tx_data & data_mask(tx_ctl[1:0]))));

    // R10
    zero_divisor_chk: assert property (@(posedge clk) disable iff (rst)
        (divisor == '0) |=> (dur_half == '0));

    // R11
    dur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $stable(divisor) && $stable(tx_ctl)) |=> $stable(dur_half));

endmodule

bind async_frame_codec frame_codec_checker #(.DIV_W(DIV_W)) u_codec_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_ctl        (tx_ctl),
    .tx_data       (tx_data),
    .tx_frame      (tx_frame),
    .tx_len        (tx_len),
    .rx_ctl        (rx_ctl),
    .rx_frame      (rx_frame),
    .rx_data       (rx_data),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err),
    .divisor       (divisor),
    .dur_half      (dur_half)
);

// File: tb/test_async_frame_codec.sv
`timescale 1ns/1ps
module test_async_frame_codec;

    localparam int DIV_W = 16;
    localparam int DUR_W = DIV_W + 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [5:0]       tx_ctl = '0;
    logic [7:0]       tx_data = '0;
    logic [10:0]      tx_frame;
    logic [3:0]       tx_len;
    logic [5:0]       rx_ctl = 6'b000011;
    logic [10:0]      rx_frame = 11'h3FF;
    logic [7:0]       rx_data;
    logic             rx_parity_err;
    logic             rx_frame_err;
    logic [DIV_W-1:0] divisor = '0;
    logic [DUR_W-1:0] dur_half;

    always #10 clk = ~clk;

    async_frame_codec #(.DIV_W(DIV_W)) i_async_frame_codec (
        .clk(clk), .rst(rst), .tx_ctl(tx_ctl), .tx_data(tx_data),
        .tx_frame(tx_frame), .tx_len(tx_len), .rx_ctl(rx_ctl),
        .rx_frame(rx_frame), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .divisor(divisor), .dur_half(dur_half)
    );

    typedef struct {
        logic [10:0]      frame;
        logic [3:0]       len;
        logic [7:0]       rdata;
        logic             perr;
        logic             ferr;
        logic [DUR_W-1:0] dur;
        string            tag;
    } exp_t;

    exp_t             sb[$];
    int               n_vec = 0;
    int               n_fail = 0;
    logic [DUR_W-1:0] prev_dur = '0;
    bit               done = 0;

    function automatic int nbits(input logic [5:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic void model_enc(input logic [5:0] c, input logic [7:0] d,
                                      output logic [10:0] f, output logic [3:0] l);
        int  p = nbits(c);
        bit  x = 0;
        f = '0;
        for (int i = 0; i < p; i++) begin
            f[i] = d[i];
            x ^= d[i];
        end
        if (c[3]) begin
            f[p] = c[5] ? 1'b1 : (c[4] ? x : !x);
            p++;
        end
        f[p] = 1'b1; p++;
        if (c[2]) begin f[p] = 1'b1; p++; end
        l = 4'(p);
    endfunction

    function automatic void model_chk(input logic [5:0] c, input logic [10:0] f,
                                      output logic [7:0] d, output logic pe,
                                      output logic fe);
        int p = nbits(c);
        bit x = 0;
        d = '0;
        for (int i = 0; i < p; i++) begin
            d[i] = f[i];
            x ^= f[i];
        end
        pe = 1'b0;
        if (c[3]) begin
            if (c[5]) pe = !f[p];
            else      pe = c[4] ? (x ^ f[p]) : !(x ^ f[p]);
            p++;
        end
        fe = !f[p];
        if (c[2]) fe = fe | !f[p+1];
    endfunction

    function automatic logic [DUR_W-1:0] model_dur(input logic [5:0] c,
                                                   input logic [DIV_W-1:0] dv);
        int h = 2 * (1 + nbits(c) + int'(c[3]));
        if (!c[2])              h += 2;
        else if (nbits(c) == 5) h += 3;
        else                    h += 4;
        return DUR_W'(dv) * DUR_W'(h);
    endfunction

    task automatic fail_line(input string tag, input string what,
                             input longint act, input longint exp);
        n_fail++;
        $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    endtask

    task automatic apply(input logic [5:0] tc, input logic [7:0] td,
                         input logic [5:0] rc, input logic [10:0] rf,
                         input logic [DIV_W-1:0] dv, input string tag);
        exp_t e;
        logic [10:0] f; logic [3:0] l;
        logic [7:0] d; logic pe, fe;
        @(negedge clk);
        tx_ctl = tc; tx_data = td; rx_ctl = rc; rx_frame = rf; divisor = dv;
        model_enc(tc, td, f, l);
        model_chk(rc, rf, d, pe, fe);
        e.frame = f; e.len = l; e.rdata = d; e.perr = pe; e.ferr = fe;
        e.dur = model_dur(tc, dv); e.tag = tag;
        // R11: before the next edge the old duration must still be shown
        #1;
        n_vec++;
        if (dur_half !== prev_dur) fail_line("R11", "dur_half before edge", dur_half, prev_dur);
        prev_dur = e.dur;
        sb.push_back(e);
    endtask

    task automatic apply_loop(input logic [5:0] c, input logic [7:0] td,
                              input logic [DIV_W-1:0] dv, input string tag);
        logic [10:0] f; logic [3:0] l;
        model_enc(c, td, f, l);
        apply(c, td, c, f, dv, tag);
    endtask

    // scoreboard monitor
    always begin
        exp_t e;
        @(posedge clk);
        if (sb.size() != 0) begin
            e = sb.pop_front();
            #2;
            n_vec++;
            if (tx_frame !== e.frame)     fail_line(e.tag, "tx_frame", tx_frame, e.frame);
            if (tx_len !== e.len)         fail_line(e.tag, "tx_len", tx_len, e.len);
            if (rx_data !== e.rdata)      fail_line(e.tag, "rx_data", rx_data, e.rdata);
            if (rx_parity_err !== e.perr) fail_line(e.tag, "rx_parity_err", rx_parity_err, e.perr);
            if (rx_frame_err !== e.ferr)  fail_line(e.tag, "rx_frame_err", rx_frame_err, e.ferr);
            if (dur_half !== e.dur)       fail_line(e.tag, "dur_half", dur_half, e.dur);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_vec++;
        if (dur_half !== '0) fail_line("R11", "dur_half in reset", dur_half, 0);
        @(negedge clk);
        rst = 1'b0;
        prev_dur = model_dur(tx_ctl, divisor);
        @(negedge clk);

        apply_loop(6'b000011, 8'hA5, 16'd1,  "R1");
        apply_loop(6'b000000, 8'hFF, 16'd3,  "R1");
        apply_loop(6'b011011, 8'h07, 16'd2,  "R2");
        apply_loop(6'b011001, 8'h2C, 16'd5,  "R2");
        apply_loop(6'b001010, 8'h15, 16'd4,  "R3");
        apply_loop(6'b001011, 8'hF0, 16'd4,  "R3");
        apply_loop(6'b101011, 8'h00, 16'd9,  "R4");
        apply_loop(6'b111000, 8'h01, 16'd9,  "R4");
        apply_loop(6'b000101, 8'h3C, 16'd6,  "R5");
        apply_loop(6'b011111, 8'h81, 16'd6,  "R5");
        apply(6'b000001, 8'h00, 6'b000001, 11'h7FF, 16'd1, "R6");
        apply(6'b000001, 8'h00, 6'b000000, 11'h0FF, 16'd1, "R6");
        apply(6'b000011, 8'h00, 6'b101011, 11'h3AA, 16'd2, "R7");
        apply(6'b000011, 8'h00, 6'b111011, 11'h2AA, 16'd2, "R7");
        apply(6'b000011, 8'h00, 6'b011011, 11'h301, 16'd2, "R8");
        apply(6'b000011, 8'h00, 6'b001011, 11'h301, 16'd2, "R8");
        apply(6'b000011, 8'h00, 6'b000011, 11'h2A5, 16'd2, "R8");
        apply(6'b000011, 8'h00, 6'b000011, 11'h0A5, 16'd2, "R9");
        apply(6'b000011, 8'h00, 6'b000111, 11'h1A5, 16'd2, "R9");
        apply(6'b000011, 8'h00, 6'b000111, 11'h3A5, 16'd2, "R9");
        apply(6'b000100, 8'h11, 6'b000000, 11'h3FF, 16'd7, "R10");
        apply(6'b011111, 8'h11, 6'b000000, 11'h3FF, 16'hFFFF, "R10");
        apply(6'b001000, 8'h11, 6'b000000, 11'h3FF, 16'd0, "R10");
        apply(6'b001000, 8'h11, 6'b000000, 11'h3FF, 16'd12, "R11");
        apply(6'b001000, 8'h11, 6'b000000, 11'h3FF, 16'd12, "R11");
        apply_loop(6'b011110, 8'h5A, 16'd3, "R12");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule